// File: doc/BRIEF.md
# Dual-Path SPI Serial Clock Divider

This block makes the serial clock of an SPI master from the core clock. It contains two dividers. The coarse divider scales the core clock by four and then by a power of two. The fine divider scales it by two and then by a linear factor. A select bit picks which divider drives the output. Both divider codes and the select bit are taken as fields of two 32-bit control words that a register file supplies: a main configuration word and an enhanced-control word.

While the shift engine reports a transfer in progress, the block produces two outputs. One is a single-cycle enable tick at twice the serial clock rate. The other is a serial clock with a 50% duty cycle that toggles on every tick. While no transfer is running, the clock sits at its idle polarity and the counters stay cleared.

A new code or a new select value takes effect only when the current serial clock period ends, so the output never shows a runt pulse. A build parameter can remove the fine divider and the select logic. In that case the coarse divider alone drives the output.

Top module: `spi_clk_div`

## Requirements
- R1: With the coarse path selected, the SCLK period is 4*2^N core cycles, where N is bits 18:16 of `cfg_word_i`.
- R2: With the fine path selected, the SCLK period is 2*(N+1) core cycles, where N is bits 23:16 of `enh_word_i`.
- R3: Bit 24 of `enh_word_i` picks the path: 0 selects the coarse path and 1 selects the fine path.
- R4: Bits 15:0 of `enh_word_i`, which carry a clock-to-select delay value, and all bits of both words outside the code and select fields have no effect on SCLK.
- R5: During a transfer, each high phase and each low phase of SCLK lasts exactly half a period.
- R6: `tick_o` is a one-cycle pulse. It fires twice per SCLK period, and only in the cycle just before SCLK toggles.
- R7: While `busy_i` is low, `sclk_o` equals `cpol_i` and `tick_o` stays low.
- R8: The counters start from zero when `busy_i` rises, so the first SCLK edge appears half a period after the first cycle in which `busy_i` is high.
- R9: A change to a code or to the select bit during a transfer is applied only at the end of the current SCLK period, meaning the toggle back to the idle level. Until then, the current period completes with the old setting.
- R10: With `HAS_LINEAR` = 0, the select bit is ignored and the coarse path always drives SCLK.
- R11: During and right after reset, `sclk_o` and `tick_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Transfer in progress, from the shift engine |
| cpol_i | input | 1 | Idle level of SCLK |
| cfg_word_i | input | 32 | Main configuration word; coarse code in bits 18:16 |
| enh_word_i | input | 32 | Enhanced-control word; fine code in bits 23:16, select in bit 24, delay field in bits 15:0 |
| tick_o | output | 1 | Enable pulse at twice the SCLK rate |
| sclk_o | output | 1 | Serial clock |

## Verification
The bench builds two copies of the block side by side. One uses `HAS_LINEAR` = 1 and the other uses `HAS_LINEAR` = 0, with the 3-bit and 8-bit code widths at their defaults. The first copy gives access to every coarse code, the fine codes from 0 to 255, and changes of code in the middle of a transfer. The second copy is driven with the select bit set, which shows that a build without the fine path cannot be switched away from the coarse divider. Period, duty cycle and tick count are measured at the ports.

// File: rtl/spi_clk_div_pkg.sv
package spi_clk_div_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned P2_LSB    = 16;
  localparam int unsigned LIN_LSB   = 16;
  localparam int unsigned SEL_BIT   = 24;
endpackage

// File: rtl/spi_clk_pow2_path.sv
module spi_clk_pow2_path #(
  parameter int unsigned CODE_W = 3,
  localparam int unsigned CNT_W = 2 ** CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  logic [CNT_W-1:0] cnt_q, limit;

  // half period = 2^(code+1) core cycles
  assign limit  = ~(({CNT_W{1'b1}} << code_i) << 1);
  assign tick_o = run_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || clr_i)    cnt_q <= '0;
    else if (cnt_q == limit)     cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  a_r5_p2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= limit);
endmodule

// File: rtl/spi_clk_lin_path.sv
module spi_clk_lin_path #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  logic [CODE_W-1:0] cnt_q;

  // half period = code+1 core cycles
  assign tick_o = run_i && (cnt_q == code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || clr_i) cnt_q <= '0;
    else if (cnt_q == code_i) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  a_r5_lin_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= code_i);
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_clk_div_pkg::*;
#(
  parameter bit          HAS_LINEAR = 1'b1,
  parameter int unsigned P2_W       = 3,
  parameter int unsigned LIN_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              cpol_i,
  input  logic [WORD_W-1:0] cfg_word_i,
  input  logic [WORD_W-1:0] enh_word_i,
  output logic              tick_o,
  output logic              sclk_o
);
  logic [P2_W-1:0]  p2_in, p2_q;
  logic [LIN_W-1:0] lin_in, lin_q;
  logic             sel_in, sel_q;
  logic             sclk_q;
  logic             p2_tick, lin_tick, tick, boundary;
  logic             unused_words;

  assign unused_words = ^{cfg_word_i, enh_word_i};
  assign p2_in  = cfg_word_i[P2_LSB +: P2_W];
  assign lin_in = enh_word_i[LIN_LSB +: LIN_W];

  spi_clk_pow2_path #(.CODE_W(P2_W)) u_p2 (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(busy_i), .clr_i(boundary),
    .code_i(p2_q), .tick_o(p2_tick)
  );

  generate
    if (HAS_LINEAR) begin : g_lin
      assign sel_in = enh_word_i[SEL_BIT];
      spi_clk_lin_path #(.CODE_W(LIN_W)) u_lin (
        .clk_i (clk_i), .rst_ni(rst_ni), .run_i(busy_i), .clr_i(boundary),
        .code_i(lin_q), .tick_o(lin_tick)
      );
    end else begin : g_nolin
      assign sel_in   = 1'b0;
      assign lin_tick = 1'b0;
    end
  endgenerate

  assign tick     = busy_i && (sel_q ? lin_tick : p2_tick);
  // period ends on the toggle back to the idle level
  assign boundary = tick && (sclk_q != cpol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      sel_q  <= 1'b0;
      p2_q   <= '0;
      lin_q  <= '0;
    end else if (!busy_i) begin
      sclk_q <= cpol_i;
      sel_q  <= sel_in;
      p2_q   <= p2_in;
      lin_q  <= lin_in;
    end else begin
      if (tick) sclk_q <= ~sclk_q;
      if (boundary) begin
        sel_q <= sel_in;
        p2_q  <= p2_in;
        lin_q <= lin_in;
      end
    end
  end

  assign tick_o = tick;
  assign sclk_o = sclk_q;

  a_r7_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> sclk_o == $past(cpol_i));
  a_r7_no_idle_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> busy_i);
  a_r6_toggle_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && sclk_o != $past(sclk_o)) |-> $past(tick_o));
  a_r9_hold_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_i) && !$past(boundary)) |-> ($stable(sel_q) && $stable(p2_q) && $stable(lin_q)));
  a_r10_sel_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_LINEAR |-> !sel_q);
endmodule

// File: tb/tb_spi_clk_div.sv
module tb_spi_clk_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busy = 1'b0;
  logic        cpol = 1'b0;
  logic [31:0] cfg_w = '0;
  logic [31:0] enh_w = '0;
  logic        tick, sclk, tick2, sclk2;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  spi_clk_div #(.HAS_LINEAR(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .cpol_i(cpol),
    .cfg_word_i(cfg_w), .enh_word_i(enh_w), .tick_o(tick), .sclk_o(sclk));

  spi_clk_div #(.HAS_LINEAR(1'b0)) dut_p2 (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .cpol_i(cpol),
    .cfg_word_i(cfg_w), .enh_word_i(enh_w), .tick_o(tick2), .sclk_o(sclk2));

  typedef struct packed {
    logic        sel;
    logic [7:0]  code;
    logic [15:0] dly;
    logic [31:0] per;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'd0, 16'h0000,   4}, '{1'b0, 8'd1, 16'hFFFF,   8},
    '{1'b0, 8'd2, 16'h1234,  16}, '{1'b0, 8'd3, 16'h00FF,  32},
    '{1'b0, 8'd4, 16'hA5A5,  64}, '{1'b0, 8'd5, 16'h0001, 128},
    '{1'b0, 8'd6, 16'h8000, 256}, '{1'b0, 8'd7, 16'hFFFF, 512},
    '{1'b1, 8'd0, 16'hFFFF,   2}, '{1'b1, 8'd1, 16'h0000,   4},
    '{1'b1, 8'd2, 16'h5A5A,   6}, '{1'b1, 8'd7, 16'h0F0F,  16},
    '{1'b1, 8'd99, 16'h7777, 200}, '{1'b1, 8'd254, 16'hFFFF, 510},
    '{1'b1, 8'd255, 16'h0000, 512}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_words(input logic sel, input logic [7:0] code, input logic [15:0] dly);
    if (sel) begin
      cfg_w = {13'h1FFF, 3'd5, dly};
      enh_w = {7'h7F, 1'b1, code, dly};
    end else begin
      cfg_w = {13'h1FFF, code[2:0], dly};
      enh_w = {7'h7F, 1'b0, 8'h33, dly};
    end
  endtask

  // period, high-phase samples and ticks between two rising edges
  task automatic measure(input bit use_p2, input int lim,
                         output int per, output int hi, output int tk);
    int r0, r1, idx, nrise;
    logic prev, s, t;
    r0 = 0; r1 = 0; idx = 0; nrise = 0; hi = 0; tk = 0; prev = 1'b0;
    busy = 1'b0;
    repeat (3) @(negedge clk);
    busy = 1'b1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      idx++;
      s = use_p2 ? sclk2 : sclk;
      t = use_p2 ? tick2 : tick;
      if (nrise == 2) begin
        if (s) hi++;
        if (t) tk++;
      end
      if (s && !prev) begin
        nrise++;
        if (nrise == 2) begin r0 = idx; hi = 1; tk = t ? 1 : 0; end
        if (nrise == 3) begin r1 = idx; hi--; if (t) tk--; break; end
      end
      prev = s;
    end
    per = r1 - r0;
    busy = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int per, hi, tk, n;
    // R11: reset state
    repeat (2) @(negedge clk);
    chk("R11 sclk in reset", int'(sclk), 0);
    chk("R11 tick in reset", int'(tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 sclk after reset", int'(sclk), 0);

    // R1 R2 R3 R4 R5 R6: table sweep
    for (int v = 0; v < NV; v++) begin
      set_words(VEC[v].sel, VEC[v].code, VEC[v].dly);
      measure(1'b0, 4 * int'(VEC[v].per) + 20, per, hi, tk);
      chk(VEC[v].sel ? "R2 R3 R4 fine period" : "R1 R3 R4 coarse period", per, int'(VEC[v].per));
      chk("R5 high phase", hi, int'(VEC[v].per) / 2);
      chk("R6 ticks per period", tk, 2);
    end

    // R10: no fine path, select bit set
    set_words(1'b1, 8'd3, 16'h0);
    cfg_w[18:16] = 3'd2;
    measure(1'b1, 200, per, hi, tk);
    chk("R10 coarse forced", per, 16);

    // R7: idle with cpol high
    cpol = 1'b1;
    busy = 1'b0;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sclk && !tick) n++;
    end
    chk("R7 idle level held", n, 20);
    cpol = 1'b0;

    // R8: first edge half a period after start (fine code 4 -> half 5)
    set_words(1'b1, 8'd4, 16'h0);
    repeat (3) @(negedge clk);
    busy = 1'b1;
    n = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      n++;
      if (sclk) break;
    end
    chk("R8 first edge delay", n, 5);
    busy = 1'b0;

    // R9: code change mid high phase (fine 9 -> fine 1)
    set_words(1'b1, 8'd9, 16'h0);
    repeat (3) @(negedge clk);
    busy = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sclk) break;
    end
    set_words(1'b1, 8'd1, 16'h0);
    hi = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sclk) hi++; else break;
    end
    chk("R9 old high phase kept", hi, 10);
    n = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!sclk) n++; else break;
    end
    chk("R9 new low phase", n, 2);
    hi = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sclk) hi++; else break;
    end
    chk("R9 new high phase", hi, 2);
    busy = 1'b0;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule